// File: doc/BRIEF.md
# PCM Serial Transmit Port

This block sends one voice sample per frame as a serial bit stream on a data pin that has its own output enable, so several devices can share one wire. It runs from a fast system clock. An external bit clock and an 8 kHz frame sync are brought into that clock domain and reduced to single-cycle edge events. Software-free logic upstream writes each new 13-bit two's-complement sample with a strobe. The port copies the sample into its shift register when a frame begins, then launches it MSB first, one bit on each rising edge of the bit clock.

Each sync pulse is sorted as short or long by how many bit-clock falling edges see it high. The class found for one pulse sets the enable timing of the following frame. In short timing the pin drives from the first rising edge after the sync until the middle of the LSB. In long timing the pin drives from the sync sample onward, and it stays driven while the sync is high or the word is still in flight. A mode input stretches the word to 16 bits by repeating the sign at the front. After reset or a power-up, the pin stays released for two frame periods before it may drive.

Top module: `pcm_tx_port`

## Requirements
- R1: After reset is released, or after `pwr_up` goes high again, the first two frame syncs produce no driving. Driving can begin with the third sync.
- R2: A frame start is a bit-clock falling edge that samples `fsync` high when the previous falling edge sampled it low. The pulse is long if the next falling edge also samples it high, and short otherwise. Each frame uses the class of the previous pulse. Short is assumed after reset or power-up.
- R3: Bits leave MSB first, one per bit-clock rising edge. Bit 1 (the sign) appears at the first rising edge after the frame-start falling edge, and a 13-bit frame sends sample bits 12 down to 0.
- R4: In short timing, `sdo_oe` rises at the first rising edge after the frame start. It falls at the falling edge that follows the rising edge that launched the last bit.
- R5: In long timing, `sdo_oe` rises at the frame-start falling edge. It stays high while `fsync` is high or the word is unfinished, and it falls at whichever of those two ends comes later.
- R6: With `sign_ext` high at the frame start, the word is 16 bits: bits 1 to 4 all carry sample bit 12, followed by sample bits 11 down to 0. `sign_ext` is latched once per frame.
- R7: `sample_vld` stores `sample` in a holding register. The register is copied into the shifter only at a frame start, so a strobe during a word takes effect in the next frame.
- R8: A frame start that arrives before the current word has reached its LSB midpoint abandons that word and releases `sdo_oe`. No word is driven in the frame that this sync opens.
- R9: While `pwr_up` is low, `sdo_oe` is low from the next system clock on, and all frame state is cleared.
- R10: During reset `sdo_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously and is released synchronously |
| bclk | input | 1 | Serial bit clock |
| fsync | input | 1 | Frame sync, about 8 kHz |
| pwr_up | input | 1 | High while powered; low clears the port |
| sign_ext | input | 1 | High selects the 16-bit sign-extended word |
| sample | input | 13 | Two's-complement sample |
| sample_vld | input | 1 | Strobe that writes `sample` into the holding register |
| sdo | output | 1 | Serial data |
| sdo_oe | output | 1 | Output enable for `sdo`; low means high impedance |

## Verification
The assertions assume that every bit-clock phase lasts several system clocks, which gives the synchronizer and edge detector time to produce one event per edge. They also assume that `fsync` changes only while the bit clock is high, so it is stable at every falling-edge sample. The bench keeps both conditions. It holds each bit-clock phase for six system clocks and changes `fsync` only together with a bit-clock rise. It issues load strobes only between bit-clock edges and never in the cycle of a frame start. With these conditions, the edge events, shift counts and enable windows checked by the assertions follow the bit clock one for one.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
  typedef enum logic {SYNC_SHORT = 1'b0, SYNC_LONG = 1'b1} sync_kind_e;
endpackage

// File: rtl/pcm_tx_edge.sv
module pcm_tx_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic fsync,
  output logic rise_ev,
  output logic fall_ev,
  output logic fs_lvl
);
  logic [STAGES-1:0] bc_q, fs_q;
  logic              bc_last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bc_q      <= '0;
      fs_q      <= '0;
      bc_last_q <= 1'b0;
    end else begin
      bc_q      <= {bc_q[STAGES-2:0], bclk};
      fs_q      <= {fs_q[STAGES-2:0], fsync};
      bc_last_q <= bc_q[STAGES-1];
    end
  end

  assign rise_ev = bc_q[STAGES-1] & ~bc_last_q;
  assign fall_ev = ~bc_q[STAGES-1] & bc_last_q;
  assign fs_lvl  = fs_q[STAGES-1];
endmodule

// File: rtl/pcm_tx_framer.sv
module pcm_tx_framer
  import pcm_tx_pkg::*;
#(
  parameter int GUARD_FRAMES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_up,
  input  logic       fall_ev,
  input  logic       fs_lvl,
  input  logic       busy,
  output logic       launch,
  output logic       abort,
  output logic       guard_ok,
  output sync_kind_e mode_kind
);
  localparam int GW = $clog2(GUARD_FRAMES + 1);

  logic       smp_q, smp_d;
  logic       pend_q, pend_d;
  sync_kind_e cls_q, cls_d;
  logic [GW-1:0] guard_q, guard_d;
  logic       frame_start;

  assign frame_start = fall_ev && fs_lvl && !smp_q;
  assign guard_ok    = (guard_q == GW'(GUARD_FRAMES));
  assign launch      = frame_start && guard_ok && !busy;
  assign abort       = frame_start && busy;
  assign mode_kind   = cls_q;

  always_comb begin
    smp_d   = smp_q;
    pend_d  = pend_q;
    cls_d   = cls_q;
    guard_d = guard_q;
    if (!pwr_up) begin
      smp_d   = 1'b0;
      pend_d  = 1'b0;
      cls_d   = SYNC_SHORT;
      guard_d = '0;
    end else if (fall_ev) begin
      smp_d = fs_lvl;
      if (frame_start) begin
        pend_d = 1'b1;
        if (!guard_ok) guard_d = guard_q + GW'(1);
      end else if (pend_q) begin
        pend_d = 1'b0;
        cls_d  = fs_lvl ? SYNC_LONG : SYNC_SHORT;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q   <= 1'b0;
      pend_q  <= 1'b0;
      cls_q   <= SYNC_SHORT;
      guard_q <= '0;
    end else begin
      smp_q   <= smp_d;
      pend_q  <= pend_d;
      cls_q   <= cls_d;
      guard_q <= guard_d;
    end
  end

  AST_GUARD_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    guard_q <= GW'(GUARD_FRAMES)); // R1
endmodule

// File: rtl/pcm_tx_shifter.sv
module pcm_tx_shifter
  import pcm_tx_pkg::*;
#(
  parameter int DATA_W   = 13,
  parameter int EXT_BITS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_up,
  input  logic              rise_ev,
  input  logic              fall_ev,
  input  logic              fs_lvl,
  input  logic              launch,
  input  logic              abort,
  input  sync_kind_e        mode_kind,
  input  logic              sign_ext,
  input  logic [DATA_W-1:0] sample,
  input  logic              sample_vld,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              busy
);
  localparam int WORD_W = DATA_W + EXT_BITS;
  localparam int CNT_W  = $clog2(WORD_W + 1);

  logic [DATA_W-1:0] hold_q, hold_d;
  logic [WORD_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, nbits;
  logic              act_q, act_d, drv_q, drv_d, lhold_q, lhold_d;
  logic              ext_q, ext_d, long_q, long_d, finish;

  assign nbits  = ext_q ? CNT_W'(WORD_W) : CNT_W'(DATA_W);
  assign finish = fall_ev && act_q && (cnt_q == nbits);
  assign busy   = act_q && !finish;
  assign sdo    = sr_q[WORD_W-1];
  assign sdo_oe = (act_q && drv_q) || lhold_q;

  always_comb begin
    hold_d  = hold_q;
    sr_d    = sr_q;
    cnt_d   = cnt_q;
    act_d   = act_q;
    drv_d   = drv_q;
    lhold_d = lhold_q;
    ext_d   = ext_q;
    long_d  = long_q;
    if (!pwr_up) begin
      hold_d  = '0;
      sr_d    = '0;
      cnt_d   = '0;
      act_d   = 1'b0;
      drv_d   = 1'b0;
      lhold_d = 1'b0;
      ext_d   = 1'b0;
      long_d  = 1'b0;
    end else begin
      if (sample_vld) hold_d = sample;
      if (abort) begin
        act_d   = 1'b0;
        drv_d   = 1'b0;
        lhold_d = 1'b0;
      end else if (launch) begin
        sr_d    = sign_ext ? {{EXT_BITS{hold_q[DATA_W-1]}}, hold_q}
                           : {hold_q, {EXT_BITS{1'b0}}};
        cnt_d   = '0;
        act_d   = 1'b1;
        ext_d   = sign_ext;
        long_d  = (mode_kind == SYNC_LONG);
        drv_d   = (mode_kind == SYNC_LONG);
        lhold_d = (mode_kind == SYNC_LONG);
      end else begin
        if (rise_ev && act_q) begin
          if (cnt_q == '0) begin
            cnt_d = CNT_W'(1);
            drv_d = 1'b1;
          end else if (cnt_q < nbits) begin
            sr_d  = {sr_q[WORD_W-2:0], 1'b0};
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        if (finish) begin
          act_d = 1'b0;
          drv_d = 1'b0;
        end
        if (!fs_lvl) lhold_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      sr_q    <= '0;
      cnt_q   <= '0;
      act_q   <= 1'b0;
      drv_q   <= 1'b0;
      lhold_q <= 1'b0;
      ext_q   <= 1'b0;
      long_q  <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      sr_q    <= sr_d;
      cnt_q   <= cnt_d;
      act_q   <= act_d;
      drv_q   <= drv_d;
      lhold_q <= lhold_d;
      ext_q   <= ext_d;
      long_q  <= long_d;
    end
  end

  AST_PWRDN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_up |=> !sdo_oe); // R9
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= nbits); // R6
  AST_SHORT_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    act_q && !long_q && (cnt_q == '0) |-> !sdo_oe); // R4
  AST_SHIFT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    act_q && $past(act_q) && !$past(launch) && (sr_q != $past(sr_q)) |-> $past(rise_ev)); // R3
endmodule

// File: rtl/pcm_tx_port.sv
module pcm_tx_port
  import pcm_tx_pkg::*;
#(
  parameter int DATA_W       = 13,
  parameter int EXT_BITS     = 3,
  parameter int GUARD_FRAMES = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk,
  input  logic              fsync,
  input  logic              pwr_up,
  input  logic              sign_ext,
  input  logic [DATA_W-1:0] sample,
  input  logic              sample_vld,
  output logic              sdo,
  output logic              sdo_oe
);
  logic [1:0] rst_pipe_q;
  logic       rst_n_s;
  logic       rise_ev, fall_ev, fs_lvl;
  logic       launch, abort, busy, guard_ok;
  sync_kind_e mode_kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  pcm_tx_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n_s), .bclk(bclk), .fsync(fsync),
    .rise_ev(rise_ev), .fall_ev(fall_ev), .fs_lvl(fs_lvl)
  );

  pcm_tx_framer #(.GUARD_FRAMES(GUARD_FRAMES)) u_framer (
    .clk(clk), .rst_n(rst_n_s), .pwr_up(pwr_up), .fall_ev(fall_ev),
    .fs_lvl(fs_lvl), .busy(busy), .launch(launch), .abort(abort),
    .guard_ok(guard_ok), .mode_kind(mode_kind)
  );

  pcm_tx_shifter #(.DATA_W(DATA_W), .EXT_BITS(EXT_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n_s), .pwr_up(pwr_up), .rise_ev(rise_ev),
    .fall_ev(fall_ev), .fs_lvl(fs_lvl), .launch(launch), .abort(abort),
    .mode_kind(mode_kind), .sign_ext(sign_ext), .sample(sample),
    .sample_vld(sample_vld), .sdo(sdo), .sdo_oe(sdo_oe), .busy(busy)
  );

  AST_GUARD_BEFORE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n_s)
    sdo_oe |-> guard_ok); // R1
endmodule

// File: tb/sim_pcm_tx_port.sv
module sim_pcm_tx_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;

  logic clk = 1'b0;
  logic rst_n, bclk, fsync, pwr_up, sign_ext, sample_vld;
  logic [12:0] sample;
  logic sdo, sdo_oe;

  int checks = 0, failures = 0;
  int starts = 0, prev_len = 0, prev_n = 13;
  bit prev_long = 0, prev_drove = 0;
  logic [12:0] hold = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcm_tx_port u0 (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .pwr_up(pwr_up),
    .sign_ext(sign_ext), .sample(sample), .sample_vld(sample_vld),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic load(input logic [12:0] v);
    @(negedge clk) sample = v; sample_vld = 1'b1;
    @(negedge clk) sample_vld = 1'b0;
    hold = v;
  endtask

  task automatic step(input logic fs, output logic r_oe, output logic r_sdo, output logic f_oe);
    @(negedge clk) bclk = 1'b1; fsync = fs;
    repeat (HALF-1) @(negedge clk);
    r_oe = sdo_oe; r_sdo = sdo;
    @(negedge clk) bclk = 1'b0;
    repeat (HALF-1) @(negedge clk);
    f_oe = sdo_oe;
  endtask

  // One frame; the expected enable and data come from the bench's own model.
  task automatic frame(input int len, input int lp, input bit mid_en,
                       input logic [12:0] mid_val, input string dtag);
    int n;
    bit drive, lm, trunc_prev;
    logic [15:0] w;
    string otag;
    n = sign_ext ? 16 : 13;
    trunc_prev = prev_drove && (prev_len < prev_n);
    drive = (starts >= 2) && !trunc_prev;
    lm = prev_long;
    w = sign_ext ? {{3{hold[12]}}, hold} : {hold, 3'b000};
    otag = (starts < 2) ? "R1" : trunc_prev ? "R8" : lm ? "R5" : "R4";
    for (int k = 0; k < len; k++) begin
      logic fsk, ro, rd, fo;
      fsk = (k < lp);
      if (mid_en && k == 5) load(mid_val);
      step(fsk, ro, rd, fo);
      if (k == 0) begin
        if (!trunc_prev) chk(ro, 1'b0, otag, "idle before sync");
        chk(fo, drive && lm, drive ? "R2" : otag, "enable at sync fall");
      end else begin
        chk(ro, drive && (k <= n || (lm && fsk)), otag, "enable high phase");
        if (drive && k <= n) chk(rd, w[16-k], dtag, "data bit");
        chk(fo, drive && (k < n || (lm && fsk)), otag, "enable low phase");
      end
    end
    prev_drove = drive;
    prev_len = len;
    prev_n = n;
    prev_long = (lp >= 2);
    starts = (starts < 2) ? starts + 1 : 2;
  endtask

  task automatic t_reset;
    repeat (4) @(negedge clk);
    chk(sdo_oe, 1'b0, "R10", "enable in reset");
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(sdo_oe, 1'b0, "R10", "enable after reset");
  endtask

  task automatic t_guard;
    load(13'h0A5C);
    frame(16, 1, 0, '0, "R1");
    frame(16, 1, 0, '0, "R1");
    frame(16, 1, 0, '0, "R3");
  endtask

  task automatic t_patterns;
    load(13'h1000); frame(16, 1, 0, '0, "R3");
    load(13'h0FFF); frame(16, 1, 0, '0, "R3");
    load(13'h1555); frame(15, 1, 0, '0, "R3");
  endtask

  task automatic t_long;
    load(13'h0333); frame(16, 3, 0, '0, "R2");
    load(13'h1C71); frame(16, 2, 0, '0, "R5");
    load(13'h02B4); frame(20, 15, 0, '0, "R5");
    load(13'h1F0F); frame(16, 1, 0, '0, "R5");
    load(13'h0E0E); frame(16, 1, 0, '0, "R2");
  endtask

  task automatic t_sign_ext;
    sign_ext = 1'b1;
    load(13'h1234); frame(18, 1, 0, '0, "R6");
    load(13'h0ABC); frame(18, 2, 0, '0, "R6");
    load(13'h1FFE); frame(18, 1, 0, '0, "R6");
    sign_ext = 1'b0;
    load(13'h0001); frame(16, 1, 0, '0, "R6");
  endtask

  task automatic t_midload;
    load(13'h1111);
    frame(16, 1, 1, 13'h0666, "R7");
    frame(16, 1, 0, '0, "R7");
  endtask

  task automatic t_abort;
    load(13'h0F0F); frame(8, 1, 0, '0, "R8");
    load(13'h1234); frame(16, 1, 0, '0, "R8");
    frame(16, 1, 0, '0, "R8");
  endtask

  task automatic t_powerdown;
    logic ro, rd, fo;
    load(13'h1AAA);
    for (int k = 0; k < 5; k++) step(k < 1, ro, rd, fo);
    chk(ro, 1'b1, "R9", "driving before power-down");
    @(negedge clk) pwr_up = 1'b0;
    @(negedge clk);
    chk(sdo_oe, 1'b0, "R9", "enable after power-down");
    repeat (10) @(negedge clk);
    chk(sdo_oe, 1'b0, "R9", "enable while powered down");
    @(negedge clk) pwr_up = 1'b1;
    starts = 0; prev_long = 0; prev_drove = 0;
    load(13'h0C3C);
    frame(16, 2, 0, '0, "R1");
    frame(16, 1, 0, '0, "R1");
    frame(16, 1, 0, '0, "R9");
  endtask

  initial begin
    rst_n = 1'b0; bclk = 1'b0; fsync = 1'b0; pwr_up = 1'b1;
    sign_ext = 1'b0; sample = '0; sample_vld = 1'b0;
    t_reset;
    t_guard;
    t_patterns;
    t_long;
    t_sign_ext;
    t_midload;
    t_abort;
    t_powerdown;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule